// File: doc/BRIEF.md
# Parallel DMA Interface Controller

This block is the register-level front end of a 16-bit parallel DMA link to an external device. A host writes a control word that drives three latched function lines, starts a transfer with a one-cycle start strobe, and can force a single transfer cycle. The same offset reads back a status word. That word gathers sticky event flags, live device inputs and the current enable state. A separate command offset turns the interrupt enable on and off. The 32-bit transfer address is written at one pair of offsets and read back at another pair.

The memory engine itself sits outside. It reports each finished word on a strobe, and it reports bus errors and bus timeouts on two inputs. For each finished word the block advances the address and counts the range down. When the range runs past zero, the end-of-range flag is set and transfers stop. An attention line is edge-detected into a sticky flag, and a parity input sets another flag. Each flag is cleared by writing a dedicated bit of the control word. The interrupt line combines the enable with the end-of-range and attention flags. A master clear returns the control state to idle and sends an initialize strobe to the device.

Top module: `pdma_ctrl`

## Requirements
- R1: After reset the status word (offset 0) reads 0x0080 when attention and the device status inputs are low. `fcn_out`, `go_pulse`, `cyc_pulse`, `init_pulse` and `irq` are 0.
- R2: A control write (offset 0, host_we high) without bit 12 loads wdata[3:1] into `fcn_out` on that edge. The latch state reads back in status bits 3..1.
- R3: A control write with bit 0 set, and without bit 12, enables DMA. Status bit 7 (ready) reads 0 and `dma_busy` reads 1. `go_pulse` is high for exactly the cycle after the write edge.
- R4: A control write with bit 8 gives a one-cycle `cyc_pulse` only if DMA was already enabled before that write. Otherwise the bit has no effect.
- R5: A `dma_word_done` strobe while DMA is enabled, with no bus fault in the same cycle, increments `dma_addr` by one and decrements the range. While DMA is disabled the strobe changes nothing.
- R6: A counted word with range 0 leaves range 0xFFFF. It sets status bit 15 (end-of-range) and disables DMA.
- R7: A false-to-true transition of `attn_in` sets status bit 14. Status bit 13 shows the live level of `attn_in`. A level held high does not set the flag again after it has been cleared.
- R8: Control bits 15, 14 and 13 clear status bits 15, 14 and 12 respectively. `perr_in` high sets status bit 12. A set in the same cycle wins over a clear.
- R9: `bus_err_in` and `bus_tmo_in` have an effect only while DMA is enabled. Then they set status bit 5 and status bit 4 respectively, set end-of-range and disable DMA. Both inputs are ignored while DMA is idle.
- R10: A write to offset 1 with bit 6 sets the interrupt enable, and with bit 5 clears it. When both bits are set, the clear wins. Control bit 6 also sets the enable. The enable reads back in status bit 6.
- R11: `irq` is high exactly when the interrupt enable is set and status bit 15 or bit 14 is set.
- R12: A control write with bit 12 clears every status flag, the function latches, the interrupt enable and the DMA enable in that edge. All other bits of that word are ignored. `init_pulse` is high for the next cycle.
- R13: Register map. Offsets 2 and 3 write the low and high address halves, and they read 0. Offsets 5 and 6 read the low and high halves. Offset 4 reads and writes the range. Offset 1 reads 0. Status bits 11..9 show `dev_stat_in`, and status bits 8 and 0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data for `host_addr`, combinational |
| attn_in | input | 1 | Device attention level |
| perr_in | input | 1 | Device parity error |
| dev_stat_in | input | 3 | Device status lines |
| fcn_out | output | 3 | Latched function lines |
| go_pulse | output | 1 | Start strobe to the device |
| cyc_pulse | output | 1 | Forced transfer cycle strobe |
| init_pulse | output | 1 | Initialize strobe after a master clear |
| dma_busy | output | 1 | DMA enabled |
| dma_addr | output | 32 | Current transfer address |
| dma_word_done | input | 1 | Engine finished one word |
| bus_err_in | input | 1 | Bus error from the engine |
| bus_tmo_in | input | 1 | Bus timeout from the engine |
| irq | output | 1 | Interrupt request |

## Verification
Register writes, counted words and input events change state on the clock edge that samples them. The new state shows on `host_rdata`, `dma_addr`, `dma_busy` and `fcn_out` from that edge on. The three strobes are high only for the cycle that follows the causing edge. `irq` follows the flags with no added delay. The bench drives inputs just after a falling edge and steps its reference model on the rising edge. It compares every output at the next falling edge, so each result is checked in the first cycle it is due. Hand-computed register reads then pin down the corner cases.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  localparam int OFS_W    = 3;
  localparam int FCN_W    = 3;
  localparam int DSTAT_W  = 3;
  localparam int NFLAG    = 5;

  // register offsets
  localparam logic [OFS_W-1:0] OFS_CTRL   = 3'd0;
  localparam logic [OFS_W-1:0] OFS_PULSE  = 3'd1;
  localparam logic [OFS_W-1:0] OFS_WA_LO  = 3'd2;
  localparam logic [OFS_W-1:0] OFS_WA_HI  = 3'd3;
  localparam logic [OFS_W-1:0] OFS_RANGE  = 3'd4;
  localparam logic [OFS_W-1:0] OFS_RA_LO  = 3'd5;
  localparam logic [OFS_W-1:0] OFS_RA_HI  = 3'd6;

  // control word bits
  localparam int CB_CLR_EOR = 15;
  localparam int CB_CLR_ATT = 14;
  localparam int CB_CLR_PAR = 13;
  localparam int CB_MCLR    = 12;
  localparam int CB_CYCLE   = 8;
  localparam int CB_IE      = 6;
  localparam int CB_FCN_LO  = 1;
  localparam int CB_GO      = 0;

  // pulse command bits
  localparam int PB_IE_SET  = 6;
  localparam int PB_IE_CLR  = 5;

  // sticky flag index
  localparam int FL_EOR  = 0;
  localparam int FL_ATT  = 1;
  localparam int FL_PAR  = 2;
  localparam int FL_BERR = 3;
  localparam int FL_TMO  = 4;
endpackage

// File: rtl/pdma_rst_sync.sv
module pdma_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/pdma_flags.sv
module pdma_flags
  import pdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mclr_i,
  input  logic             attn_i,
  input  logic [NFLAG-1:0] set_i,     // attention entry ignored, edge made here
  input  logic [NFLAG-1:0] clr_i,
  output logic [NFLAG-1:0] flags_o
);
  logic             attn_q, attn_d;
  logic [NFLAG-1:0] set_all;
  logic [NFLAG-1:0] flag_q, flag_d;

  always_comb begin
    set_all         = set_i;
    set_all[FL_ATT] = attn_i & ~attn_q;
    attn_d          = attn_i;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_comb begin
      if (mclr_i)          flag_d[g] = 1'b0;
      else if (set_all[g]) flag_d[g] = 1'b1;
      else if (clr_i[g])   flag_d[g] = 1'b0;
      else                 flag_d[g] = flag_q[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      attn_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      attn_q <= attn_d;
    end
  end

  assign flags_o = flag_q;

  a_r12_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    mclr_i |=> (flags_o == '0));
  a_r7_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (attn_i && !attn_q && !mclr_i) |=> flags_o[FL_ATT]);
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i[FL_PAR] && !mclr_i) |=> flags_o[FL_PAR]);
endmodule

// File: rtl/pdma_xfer.sv
module pdma_xfer #(
  parameter int DW = 16,
  localparam int AW = 2*DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          word_done_i,
  input  logic          stop_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic          wr_rng_i,
  input  logic [DW-1:0] wdata_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] range_o,
  output logic          underflow_o
);
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] rng_q, rng_d;
  logic          count;

  assign count = en_i & word_done_i & ~stop_i;

  always_comb begin
    addr_d = addr_q;
    rng_d  = rng_q;
    if (count) begin
      addr_d = addr_q + 1'b1;
      rng_d  = rng_q - 1'b1;
    end
    if (wr_lo_i)  addr_d[DW-1:0]  = wdata_i;
    if (wr_hi_i)  addr_d[AW-1:DW] = wdata_i;
    if (wr_rng_i) rng_d           = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rng_q  <= '0;
    end else begin
      addr_q <= addr_d;
      rng_q  <= rng_d;
    end
  end

  assign addr_o      = addr_q;
  assign range_o     = rng_q;
  assign underflow_o = count & (rng_q == '0);

  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (count && !wr_lo_i && !wr_hi_i) |=> (addr_o == $past(addr_o) + 1'b1));
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !wr_lo_i && !wr_hi_i && !wr_rng_i) |=> ($stable(addr_o) && $stable(range_o)));
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow_o && !wr_rng_i) |=> (range_o == '1));
endmodule

// File: rtl/pdma_ctrl.sv
module pdma_ctrl
  import pdma_pkg::*;
#(
  parameter int DW = 16,
  localparam int AW = 2*DW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [OFS_W-1:0]   host_addr,
  input  logic [DW-1:0]      host_wdata,
  output logic [DW-1:0]      host_rdata,
  input  logic               attn_in,
  input  logic               perr_in,
  input  logic [DSTAT_W-1:0] dev_stat_in,
  output logic [FCN_W-1:0]   fcn_out,
  output logic               go_pulse,
  output logic               cyc_pulse,
  output logic               init_pulse,
  output logic               dma_busy,
  output logic [AW-1:0]      dma_addr,
  input  logic               dma_word_done,
  input  logic               bus_err_in,
  input  logic               bus_tmo_in,
  output logic               irq
);
  logic rst_s;
  logic wr_ctrl, wr_pulse, mclr, stop, underflow;
  logic [NFLAG-1:0] fset, fclr, flags;
  logic [DW-1:0] range;

  logic [FCN_W-1:0] fcn_q, fcn_d;
  logic ie_q, ie_d, en_q, en_d;
  logic go_q, go_d, cyc_q, cyc_d, init_q, init_d;

  pdma_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s));

  // write decode
  assign wr_ctrl  = host_we & (host_addr == OFS_CTRL);
  assign wr_pulse = host_we & (host_addr == OFS_PULSE);
  assign mclr     = wr_ctrl & host_wdata[CB_MCLR];
  assign stop     = en_q & (bus_err_in | bus_tmo_in);

  always_comb begin
    fset          = '0;
    fset[FL_EOR]  = underflow | stop;
    fset[FL_PAR]  = perr_in;
    fset[FL_BERR] = en_q & bus_err_in;
    fset[FL_TMO]  = en_q & bus_tmo_in;
    fclr          = '0;
    fclr[FL_EOR]  = wr_ctrl & host_wdata[CB_CLR_EOR];
    fclr[FL_ATT]  = wr_ctrl & host_wdata[CB_CLR_ATT];
    fclr[FL_PAR]  = wr_ctrl & host_wdata[CB_CLR_PAR];
  end

  pdma_flags u_flags (
    .clk(clk), .rst_n(rst_s), .mclr_i(mclr), .attn_i(attn_in),
    .set_i(fset), .clr_i(fclr), .flags_o(flags)
  );

  pdma_xfer #(.DW(DW)) u_xfer (
    .clk(clk), .rst_n(rst_s), .en_i(en_q), .word_done_i(dma_word_done),
    .stop_i(stop),
    .wr_lo_i(host_we & (host_addr == OFS_WA_LO)),
    .wr_hi_i(host_we & (host_addr == OFS_WA_HI)),
    .wr_rng_i(host_we & (host_addr == OFS_RANGE)),
    .wdata_i(host_wdata), .addr_o(dma_addr), .range_o(range),
    .underflow_o(underflow)
  );

  // control next state
  always_comb begin
    fcn_d  = fcn_q;
    ie_d   = ie_q;
    en_d   = en_q;
    go_d   = 1'b0;
    cyc_d  = 1'b0;
    init_d = mclr;
    if (underflow | stop) en_d = 1'b0;
    if (wr_pulse) begin
      if (host_wdata[PB_IE_CLR])      ie_d = 1'b0;
      else if (host_wdata[PB_IE_SET]) ie_d = 1'b1;
    end
    if (mclr) begin
      fcn_d = '0;
      ie_d  = 1'b0;
      en_d  = 1'b0;
    end else if (wr_ctrl) begin
      fcn_d = host_wdata[CB_FCN_LO +: FCN_W];
      if (host_wdata[CB_IE]) ie_d = 1'b1;
      if (host_wdata[CB_GO]) begin
        en_d = 1'b1;
        go_d = 1'b1;
      end
      cyc_d = host_wdata[CB_CYCLE] & en_q;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      fcn_q  <= '0;
      ie_q   <= 1'b0;
      en_q   <= 1'b0;
      go_q   <= 1'b0;
      cyc_q  <= 1'b0;
      init_q <= 1'b0;
    end else begin
      fcn_q  <= fcn_d;
      ie_q   <= ie_d;
      en_q   <= en_d;
      go_q   <= go_d;
      cyc_q  <= cyc_d;
      init_q <= init_d;
    end
  end

  // read path
  always_comb begin
    host_rdata = '0;
    case (host_addr)
      OFS_CTRL: host_rdata = {flags[FL_EOR], flags[FL_ATT], attn_in, flags[FL_PAR],
                              dev_stat_in, 1'b0, ~en_q, ie_q, flags[FL_BERR],
                              flags[FL_TMO], fcn_q, 1'b0};
      OFS_RANGE: host_rdata = range;
      OFS_RA_LO: host_rdata = dma_addr[DW-1:0];
      OFS_RA_HI: host_rdata = dma_addr[AW-1:DW];
      default:   host_rdata = '0;
    endcase
  end

  assign fcn_out    = fcn_q;
  assign go_pulse   = go_q;
  assign cyc_pulse  = cyc_q;
  assign init_pulse = init_q;
  assign dma_busy   = en_q;
  assign irq        = ie_q & (flags[FL_EOR] | flags[FL_ATT]);

  logic unused_wbits;
  assign unused_wbits = ^{host_wdata[11:9], host_wdata[7], host_wdata[4]};

  a_r3_go_busy: assert property (@(posedge clk) disable iff (!rst_s)
    go_pulse |-> dma_busy);
  a_r4_cyc_needs_en: assert property (@(posedge clk) disable iff (!rst_s)
    cyc_pulse |-> $past(dma_busy));
  a_r10_ie_clear: assert property (@(posedge clk) disable iff (!rst_s)
    (wr_pulse && host_wdata[PB_IE_CLR]) |=> !irq);
  a_r11_irq_gated: assert property (@(posedge clk) disable iff (!rst_s)
    irq |-> (host_addr != OFS_CTRL || host_rdata[6]));
  a_r12_init_idle: assert property (@(posedge clk) disable iff (!rst_s)
    init_pulse |-> (!dma_busy && !irq && fcn_out == '0));
  a_r6_stop_idle: assert property (@(posedge clk) disable iff (!rst_s)
    (underflow && !mclr && !(wr_ctrl && host_wdata[CB_GO])) |=> !dma_busy);
endmodule

// File: tb/pdma_ctrl_tb.sv
module pdma_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [2:0]  host_addr = 3'd0;
  logic [15:0] host_wdata = 16'd0;
  logic [15:0] host_rdata;
  logic        attn_in = 1'b0, perr_in = 1'b0;
  logic [2:0]  dev_stat_in = 3'd0;
  logic [2:0]  fcn_out;
  logic        go_pulse, cyc_pulse, init_pulse, dma_busy, irq;
  logic [31:0] dma_addr;
  logic        dma_word_done = 1'b0, bus_err_in = 1'b0, bus_tmo_in = 1'b0;

  int n_run = 0, n_fail = 0;
  bit done_flag = 0;

  pdma_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .attn_in(attn_in),
    .perr_in(perr_in), .dev_stat_in(dev_stat_in), .fcn_out(fcn_out),
    .go_pulse(go_pulse), .cyc_pulse(cyc_pulse), .init_pulse(init_pulse),
    .dma_busy(dma_busy), .dma_addr(dma_addr), .dma_word_done(dma_word_done),
    .bus_err_in(bus_err_in), .bus_tmo_in(bus_tmo_in), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  bit m_eor, m_attf, m_perr, m_berr, m_tmo, m_ie, m_en, m_go, m_cyc, m_init, m_attq;
  bit [2:0]  m_fcn;
  bit [31:0] m_addr;
  bit [15:0] m_range;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_eor, m_attf, m_perr, m_berr, m_tmo, m_ie, m_en, m_go, m_cyc, m_init, m_attq} = '0;
      m_fcn = 0; m_addr = 0; m_range = 0;
    end else begin
      bit o_en, fault, counted, wrap, wc, mc;
      o_en    = m_en;
      fault   = o_en && (bus_err_in || bus_tmo_in);
      counted = o_en && dma_word_done && !fault;
      wrap    = counted && (m_range == 0);
      wc      = host_we && host_addr == 0;
      mc      = wc && host_wdata[12];
      if (wrap || fault) m_eor = 1; else if (wc && host_wdata[15]) m_eor = 0;
      if (attn_in && !m_attq) m_attf = 1; else if (wc && host_wdata[14]) m_attf = 0;
      if (perr_in) m_perr = 1; else if (wc && host_wdata[13]) m_perr = 0;
      if (o_en && bus_err_in) m_berr = 1;
      if (o_en && bus_tmo_in) m_tmo = 1;
      if (counted) begin m_addr++; m_range--; end
      if (host_we && host_addr == 2) m_addr[15:0]  = host_wdata;
      if (host_we && host_addr == 3) m_addr[31:16] = host_wdata;
      if (host_we && host_addr == 4) m_range       = host_wdata;
      if (wrap || fault) m_en = 0;
      if (host_we && host_addr == 1) begin
        if (host_wdata[5]) m_ie = 0; else if (host_wdata[6]) m_ie = 1;
      end
      m_go = 0; m_cyc = 0; m_init = mc;
      if (mc) begin
        {m_eor, m_attf, m_perr, m_berr, m_tmo, m_ie, m_en} = '0;
        m_fcn = 0;
      end else if (wc) begin
        m_fcn = host_wdata[3:1];
        if (host_wdata[6]) m_ie = 1;
        if (host_wdata[0]) begin m_en = 1; m_go = 1; end
        m_cyc = host_wdata[8] && o_en;
      end
      m_attq = attn_in;
    end
  end

  function automatic logic [15:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {m_eor, m_attf, attn_in, m_perr, dev_stat_in, 1'b0, !m_en, m_ie,
                    m_berr, m_tmo, m_fcn, 1'b0};
      3'd4: return m_range;
      3'd5: return m_addr[15:0];
      3'd6: return m_addr[31:16];
      default: return 16'h0;
    endcase
  endfunction

  task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare every output on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      cmp(fcn_out, m_fcn, "R2 fcn_out");
      cmp(go_pulse, m_go, "R3 go_pulse");
      cmp(cyc_pulse, m_cyc, "R4 cyc_pulse");
      cmp(dma_addr, m_addr, "R5 dma_addr");
      cmp(dma_busy, m_en, "R6 dma_busy");
      cmp(init_pulse, m_init, "R12 init_pulse");
      cmp(irq, m_ie && (m_eor || m_attf), "R11 irq");
      cmp(host_rdata, m_read(host_addr), "R13 host_rdata");
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); #1;
    host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk); #1;
    host_we = 0; host_wdata = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
    host_addr = a; #1;
    cmp(host_rdata, exp, tag);
  endtask

  task automatic word;
    @(negedge clk); #1 dma_word_done = 1;
    @(negedge clk); #1 dma_word_done = 0;
  endtask

  task automatic idle;
    @(negedge clk); #1;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    if (!done_flag) begin
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) idle();
    rd(0, 16'h0080, "R1 reset status");
    cmp(irq, 0, "R1 irq");
    cmp(fcn_out, 0, "R1 fcn_out");

    wr(0, 16'h000A);
    cmp(fcn_out, 3'b101, "R2 latch");
    rd(0, 16'h008A, "R2 readback");

    wr(4, 16'h0002); wr(2, 16'h1000); wr(3, 16'h0001);
    rd(5, 16'h1000, "R13 addr lo view");
    rd(6, 16'h0001, "R13 addr hi view");
    rd(2, 16'h0000, "R13 write-only lo");
    rd(4, 16'h0002, "R13 range");

    wr(0, 16'h0100);
    cmp(cyc_pulse, 0, "R4 no cycle when idle");
    wr(0, 16'h0001);
    cmp(go_pulse, 1, "R3 go high");
    rd(0, 16'h0000, "R3 not ready");
    idle();
    cmp(go_pulse, 0, "R3 go single cycle");
    wr(0, 16'h0100);
    cmp(cyc_pulse, 1, "R4 cycle when enabled");

    word();
    cmp(dma_addr, 32'h0001_1001, "R5 step");
    word(); word();
    rd(4, 16'hFFFF, "R6 wrap");
    rd(0, 16'h8080, "R6 end-of-range");
    cmp(dma_busy, 0, "R6 stopped");
    word();
    cmp(dma_addr, 32'h0001_1003, "R5 idle ignore");

    wr(1, 16'h0040);
    rd(0, 16'h80C0, "R10 enable");
    cmp(irq, 1, "R11 irq on eor");
    wr(0, 16'h8000);
    rd(0, 16'h00C0, "R8 clear eor");
    cmp(irq, 0, "R11 irq off");

    idle(); attn_in = 1; idle();
    rd(0, 16'h60C0, "R7 edge");
    cmp(irq, 1, "R11 irq on attention");
    wr(0, 16'h4000); idle();
    rd(0, 16'h20C0, "R7 level no reset");
    attn_in = 0;

    idle(); perr_in = 1; idle();
    rd(0, 16'h10C0, "R8 parity set");
    wr(0, 16'h2000);
    rd(0, 16'h10C0, "R8 set wins");
    perr_in = 0;
    wr(0, 16'h2000);
    rd(0, 16'h00C0, "R8 clear parity");

    wr(1, 16'h0060);
    rd(0, 16'h0080, "R10 clear wins");
    wr(0, 16'h0040);
    rd(0, 16'h00C0, "R10 control sets");

    wr(0, 16'h0041);
    rd(0, 16'h0040, "R9 running");
    idle(); bus_err_in = 1; idle(); bus_err_in = 0;
    rd(0, 16'h80E0, "R9 bus error");
    bus_tmo_in = 1; idle(); bus_tmo_in = 0;
    rd(0, 16'h80E0, "R9 timeout ignored idle");
    dev_stat_in = 3'b101;
    rd(0, 16'h8AE0, "R13 device status");

    wr(0, 16'h100F);
    cmp(init_pulse, 1, "R12 init");
    cmp(go_pulse, 0, "R12 go ignored");
    rd(0, 16'h0A80, "R12 cleared");
    cmp(irq, 0, "R12 irq");
    repeat (3) idle();

    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule